// File: doc/BRIEF.md
# System Interrupt Steering Controller

This block collects 32 level-sensitive interrupt sources and reduces them to a 16-bit processor interrupt level vector. Each source is tied to a fixed priority level by an irregular table, and several sources share a level. A source whose level in the table is 0 has no effect at all. Software masks sources through a disable register. That register has one address that sets bits and another that clears them, and its top bit switches off all delivery at once.

The level vector goes to a single processor, and a 4-bit target register names which one. Any active level-15 source also raises a broadcast flag. That flag marks level 15 pending in every processor unit and is not affected by any disable bit. The register interface is a simple 32-bit word-addressed port: writes take effect on a clock edge, and reads are combinational from the word offset.

Top module: `irq_steer_ctl`

## Requirements
- R1: Each cycle, the pending register loads the source inputs ANDed with the mapped-source mask, so its bits follow the input levels one cycle later. A read at word offset 0 returns it. Bits 23..26 and 31 (level 0) always read as zero.
- R2: A read at word offset 1 returns the disable register ANDed with 0xF05DFF80.
- R3: A write at offset 2 clears the disable bits set in (wdata & 0xF05DFF80). A write at offset 3 sets those bits. Disable bits outside that mask never change, and neither write changes pending.
- R4: A write at offset 4 stores wdata[3:0] as the target. The target reads back at offset 4 zero-extended and drives `target_o`.
- R5: `hard_lvl_o[L]` is 1 when some source with table level L is pending and not disabled. The table for sources 0..31 is 2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0. The output is registered, so a source change appears two clock edges later. Bit 0 is always 0.
- R6: Disable bit 31 drives `glob_dis_o`. While it is set, `hard_lvl_o` is zero on the following edge and stays zero.
- R7: `bcast15_o` is high while any pending source has level 15 (sources 27..30), whatever the disable register holds.
- R8: After reset, the disable register holds 0x0FA2007F (offset 1 reads 0), pending and target are 0, and all outputs are low.
- R9: Offsets 5..7 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive interrupt sources |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| target_o | output | 4 | Selected processor number |
| hard_lvl_o | output | 16 | Level vector for the target processor |
| glob_dis_o | output | 1 | Global disable active |
| bcast15_o | output | 1 | Level-15 broadcast to all processors |

## Verification
The bench sweeps every source one at a time under several disable states, then uses mixed source patterns driven from an LFSR, and compares each result with a table model. A design with a wrong table entry would light the wrong level bit. A design that let a non-writable disable bit be cleared would start delivering sources 0..6, 17, 21 or 27, which must stay silent. Setting the global-disable bit while sources are active catches a design that delivers levels anyway. Writes to the target with high garbage bits and to offsets 5..7 catch a design that leaks those bits into the target or decodes the unused offsets.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int NSRC  = 32;
  localparam int NLVL  = 16;
  localparam int LVL_W = 4;
  localparam int TGT_W = 4;
  localparam logic [NSRC-1:0] WR_MASK  = 32'hF05D_FF80;
  localparam logic [NSRC-1:0] DIS_RST  = 32'h0FA2_007F;
  localparam int GDIS_BIT = 31;

  typedef enum logic [2:0] {
    OFS_PEND = 3'd0, OFS_DIS = 3'd1, OFS_CLR = 3'd2,
    OFS_SET  = 3'd3, OFS_TGT = 3'd4
  } ofs_e;

  function automatic logic [LVL_W-1:0] src_level(input int s);
    case (s)
      0, 7:            return 4'd2;
      1, 8:            return 4'd3;
      2, 9:            return 4'd5;
      3, 10:           return 4'd7;
      4, 11, 21:       return 4'd9;
      5, 12, 22:       return 4'd11;
      6, 13, 17:       return 4'd13;
      14, 15:          return 4'd12;
      16:              return 4'd6;
      18:              return 4'd4;
      19:              return 4'd10;
      20:              return 4'd8;
      27, 28, 29, 30:  return 4'd15;
      default:         return 4'd0;
    endcase
  endfunction

  function automatic logic [NSRC-1:0] level_members(input int lvl);
    logic [NSRC-1:0] m;
    m = '0;
    for (int s = 0; s < NSRC; s++)
      if (int'(src_level(s)) == lvl && lvl != 0) m[s] = 1'b1;
    return m;
  endfunction

  function automatic logic [NSRC-1:0] mapped_mask();
    logic [NSRC-1:0] m;
    m = '0;
    for (int s = 0; s < NSRC; s++) m[s] = (src_level(s) != '0);
    return m;
  endfunction
endpackage

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_steer_pkg::*;
(
  input  logic [NSRC-1:0] active_i,
  output logic [NLVL-1:0] level_o
);
  assign level_o[0] = 1'b0;
  for (genvar l = 1; l < NLVL; l++) begin : g_lvl
    localparam logic [NSRC-1:0] MEMB = level_members(l);
    assign level_o[l] = |(active_i & MEMB);
  end
endmodule

// File: rtl/irq_dis_reg.sv
module irq_dis_reg
  import irq_steer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_en,
  input  logic            set_en,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] dis_o
);
  logic [NSRC-1:0] dis_q, dis_d;
  logic [NSRC-1:0] wm;

  assign wm = wdata & WR_MASK;

  always_comb begin
    dis_d = dis_q;
    if (clr_en) dis_d = dis_q & ~wm;
    else if (set_en) dis_d = dis_q | wm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dis_q <= DIS_RST;
    else if (clr_en || set_en) dis_q <= dis_d;
  end

  assign dis_o = dis_q;
endmodule

// File: rtl/irq_steer_ctl.sv
module irq_steer_ctl
  import irq_steer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] src_i,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [3:0]  target_o,
  output logic [15:0] hard_lvl_o,
  output logic        glob_dis_o,
  output logic        bcast15_o
);
  localparam logic [NSRC-1:0] MAPPED = mapped_mask();
  localparam logic [NSRC-1:0] L15    = level_members(15);

  logic [NSRC-1:0]  pend_q, pend_d;
  logic [NSRC-1:0]  dis;
  logic [TGT_W-1:0] tgt_q, tgt_d;
  logic             tgt_en;
  logic [NLVL-1:0]  lvl_comb, hard_q, hard_d;
  logic [NSRC-1:0]  active;

  assign pend_d = src_i & MAPPED;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  irq_dis_reg u_dis (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_en (reg_we && reg_addr == OFS_CLR),
    .set_en (reg_we && reg_addr == OFS_SET),
    .wdata  (reg_wdata),
    .dis_o  (dis)
  );

  assign tgt_en = reg_we && reg_addr == OFS_TGT;
  assign tgt_d  = reg_wdata[TGT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgt_q <= '0;
    else if (tgt_en) tgt_q <= tgt_d;
  end

  assign active = pend_q & ~dis;

  irq_level_map u_map (
    .active_i (active),
    .level_o  (lvl_comb)
  );

  assign hard_d = dis[GDIS_BIT] ? '0 : lvl_comb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hard_q <= '0;
    else        hard_q <= hard_d;
  end

  always_comb begin
    case (reg_addr)
      OFS_PEND: reg_rdata = pend_q & ~(32'h1 << GDIS_BIT);
      OFS_DIS:  reg_rdata = dis & WR_MASK;
      OFS_TGT:  reg_rdata = {{(32-TGT_W){1'b0}}, tgt_q};
      default:  reg_rdata = '0;
    endcase
  end

  assign target_o   = tgt_q;
  assign hard_lvl_o = hard_q;
  assign glob_dis_o = dis[GDIS_BIT];
  assign bcast15_o  = |(pend_q & L15);
endmodule

// File: rtl/irq_steer_ctl_chk.sv
module irq_steer_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] src_i,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic [3:0]  target_o,
  input logic [15:0] hard_lvl_o,
  input logic        glob_dis_o,
  input logic        bcast15_o
);
  p_gdis_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    glob_dis_o |=> hard_lvl_o == 16'h0);

  p_tgt_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd4) |=> target_o == $past(reg_wdata[3:0]));

  p_set_gdis_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd3 && reg_wdata[31]) |=> glob_dis_o);

  p_clr_gdis_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd2 && reg_wdata[31]) |=> !glob_dis_o);

  p_unused_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr > 3'd4) |=> ($stable(target_o) && $stable(glob_dis_o)));

  p_bcast_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i[30:27] != 4'h0) |=> bcast15_o);

  p_unmapped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd0) |-> (reg_rdata[26:23] == 4'h0 && !reg_rdata[31]));
endmodule

bind irq_steer_ctl irq_steer_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .target_o(target_o), .hard_lvl_o(hard_lvl_o), .glob_dis_o(glob_dis_o),
  .bcast15_o(bcast15_o)
);

// File: tb/test_irq_steer_ctl.sv
module test_irq_steer_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  target_o;
  logic [15:0] hard_lvl_o;
  logic        glob_dis_o, bcast15_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [31:0] m_dis;
  logic [3:0]  m_tgt;
  logic [31:0] lfsr = 32'hACE1_1234;
  localparam logic [31:0] MSK = 32'hF05D_FF80;

  always #5 clk = ~clk;

  irq_steer_ctl i_irq_steer_ctl (.*);

  function automatic int lvl(input int s);
    int t [32] = '{2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,
                   6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0};
    return t[s];
  endfunction

  function automatic logic [15:0] exp_hard(input logic [31:0] s, input logic [31:0] d);
    logic [15:0] h = '0;
    if (d[31]) return '0;
    for (int i = 0; i < 32; i++)
      if (s[i] && !d[i] && lvl(i) != 0) h[lvl(i)] = 1'b1;
    return h;
  endfunction

  function automatic logic [31:0] exp_pend(input logic [31:0] s);
    logic [31:0] p = '0;
    for (int i = 0; i < 32; i++) if (s[i] && lvl(i) != 0) p[i] = 1'b1;
    return p;
  endfunction

  function automatic logic exp_bc(input logic [31:0] s);
    logic b = 1'b0;
    for (int i = 0; i < 32; i++) if (s[i] && lvl(i) == 15) b = 1'b1;
    return b;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (a)
      3'd2: m_dis = m_dis & ~(d & MSK);
      3'd3: m_dis = m_dis | (d & MSK);
      3'd4: m_tgt = d[3:0];
      default: ;
    endcase
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    chk({tag, " R5 hard"}, {16'h0, hard_lvl_o}, {16'h0, exp_hard(src_i, m_dis)});
    chk({tag, " R7 bcast"}, {31'h0, bcast15_o}, {31'h0, exp_bc(src_i)});
    rd(3'd0, v);
    chk({tag, " R1 pend"}, v, exp_pend(src_i));
    chk({tag, " R6 gdis"}, {31'h0, glob_dis_o}, {31'h0, m_dis[31]});
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); src_i = 32'h1 << i;
      settle();
      check_all(tag);
    end
    @(negedge clk); src_i = '0;
    settle();
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    m_dis = 32'h0FA2_007F; m_tgt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    rd(3'd0, v); chk("R8 pend", v, 32'h0);
    rd(3'd1, v); chk("R8 dis", v, 32'h0);
    rd(3'd4, v); chk("R8 tgt", v, 32'h0);
    chk("R8 outs", {11'h0, target_o, hard_lvl_o, glob_dis_o}, 32'h0);

    sweep("reset-dis");

    // R2/R3: set everything writable
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R2 R3 set", v, 32'hF05D_FF80);
    @(negedge clk); src_i = 32'h7FFF_FFFF; settle();
    check_all("all-dis");
    // R3 pending untouched by set write
    wr(3'd3, 32'h0000_0100);
    rd(3'd0, v); chk("R3 pend kept", v, exp_pend(src_i));
    // clear all but global: still quiet (R6)
    wr(3'd2, 32'h7FFF_FFFF); settle();
    check_all("gdis-only");
    rd(3'd1, v); chk("R2 R3 clr", v, 32'h8000_0000);
    wr(3'd2, 32'h8000_0000); settle();
    check_all("all-en");
    @(negedge clk); src_i = '0; settle();
    sweep("all-en");

    // R6 global disable asserted while sources active
    @(negedge clk); src_i = 32'h0000_FF80; settle();
    wr(3'd3, 32'h8000_0000); settle();
    check_all("gdis-on");
    wr(3'd2, 32'h8000_0000); settle();
    check_all("gdis-off");

    // R4 target
    wr(3'd4, 32'hFFFF_FFF5);
    rd(3'd4, v); chk("R4 tgt read", v, 32'h5);
    chk("R4 tgt out", {28'h0, target_o}, {28'h0, m_tgt});
    // R9 unmapped offsets
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 32'hFFFF_FFFF);
      rd(3'(a), v); chk("R9 read", v, 32'h0);
    end
    rd(3'd4, v); chk("R9 tgt kept", v, 32'h5);
    rd(3'd1, v); chk("R9 dis kept", v, m_dis & MSK);

    // mixed patterns
    for (int k = 0; k < 60; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (k % 3 == 0) wr(3'd3, lfsr ^ 32'h5A5A_0F0F);
      else if (k % 3 == 1) wr(3'd2, lfsr);
      @(negedge clk); src_i = {lfsr[15:0], lfsr[31:16]}; settle();
      check_all("mixed");
      rd(3'd1, v); chk("R2 mixed", v, m_dis & MSK);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule